// File: doc/BRIEF.md
# Serial Frame Transmitter with Idle Lead-in and Break Sequencing

This block serialises bytes onto an asynchronous line as start, eight data bits sent least significant first, and stop. Each bit lasts from one bit-rate tick to the next. The tick comes from outside the block, so the block does no baud-rate division of its own.

A four-bit control register does four things:
- it enables the transmitter;
- it requests break characters;
- it gates two interrupt requests, one for "data register empty" and one for "transmission complete".

Two control sequences are remembered and carried out at the next frame boundary:
- Clearing and then setting the enable bit while a frame is on the line queues ten bit times of idle line.
- Setting and then clearing the break bit queues one break frame.

When the enable bit rises while the line is quiet, the line holds high for one bit time before anything is shifted out.

Top module: `sertx_top`

## Requirements
- R1: After reset the control register is zero, `ser_out` is 1, `dre_flag` and `tc_flag` are 1, and both interrupt requests are 0.
- R2: A control write that changes bit 0 (enable) from 0 to 1 while no frame is on the line holds `ser_out` at 1 for one bit interval before the next frame starts.
- R3: A data frame is one bit per `bit_tick` interval: 0, then the data bits with bit 0 first, then 1. Frames start and end only on a `bit_tick`, and queued frames follow one another with no gap.
- R4: `dre_flag` clears on a data write and sets on the tick at which the written byte starts on the line.
- R5: `tc_flag` sets on the tick that ends a frame (data, idle lead-in, break or start delay) when no further frame starts on that tick. It clears on a data write or when a frame starts.
- R6: `irq_empty` equals control bit 2 AND `dre_flag`. `irq_done` equals control bit 3 AND `tc_flag`.
- R7: Clearing and then setting bit 0 while a frame is on the line sends 10 bit times of 1 after that frame, before any pending data.
- R8: Setting and then clearing bit 1 (break) while a frame is on the line sends one break after that frame: 10 bit times of 0 followed by one bit time of 1.
- R9: While bit 1 and bit 0 are both 1, break frames are sent back to back. A release of bit 1 during a break adds one further break.
- R10: While bit 0 is 0 and no frame is in progress, `ser_out` stays 1 and a written byte stays pending (`dre_flag` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control value: bit0 enable, bit1 break, bit2 empty-interrupt enable, bit3 complete-interrupt enable |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | DATA_W | Byte to send |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| ser_out | output | 1 | Serial line |
| dre_flag | output | 1 | Data register empty |
| tc_flag | output | 1 | Transmission complete |
| irq_empty | output | 1 | Gated data-register-empty request |
| irq_done | output | 1 | Gated transmission-complete request |

## Verification
The bench keeps the defaults: DATA_W of 8, so a data frame is 10 bits, and BRK_BITS of 10, so a break is 11 bits including its trailing high bit. It spaces ticks a few clock cycles apart, so control and data writes can be placed strictly between two bit boundaries. That placement lets it raise the enable bit and release the break bit in the middle of a frame and compare the whole line sequence bit by bit. It also builds three consecutive breaks from a held-then-released break bit, and sends a stream of random bytes back to back.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
// Assumes: control register fields are packed with enable at bit 0.
package sertx_pkg;

    localparam int CTL_W = 4;

    // Control register layout, enable in bit 0
    typedef struct packed {
        logic ie_done;
        logic ie_empty;
        logic brk;
        logic en;
    } ctl_t;

    // Kind of frame chosen at a bit boundary
    typedef enum logic [2:0] {
        FK_NONE,
        FK_LEAD,
        FK_PRE,
        FK_BRK,
        FK_DATA
    } frame_kind_e;

endpackage

// File: rtl/sertx_ctrl.sv
// Control register and edge detection of the enable and break bits.
// Assumes: writes are single-cycle strobes; line_busy comes from the shifter.
module sertx_ctrl
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CTL_W-1:0] ctrl_wdata,
    input  logic             line_busy,
    output ctl_t             ctl,
    output logic             lead_req,
    output logic             pre_req,
    output logic             brk_rel
);

    ctl_t nxt;
    logic en_rise;

    // Decode the written value and compare it with the held one
    always_comb begin
        nxt      = ctl_t'(ctrl_wdata);
        en_rise  = ctrl_we && !ctl.en && nxt.en;
        lead_req = en_rise && !line_busy;
        pre_req  = en_rise && line_busy;
        brk_rel  = ctrl_we && ctl.brk && !nxt.brk;
    end

    // Hold the control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl <= '0;
        else if (ctrl_we) ctl <= nxt;
    end

endmodule

// File: rtl/sertx_sched.sv
// Pending-work tracking and frame selection at each bit boundary.
// Assumes: slot marks a tick at which a new frame may start; frame_end marks
// the tick that ends the current frame. Priority: delay, lead-in, break, data.
module sertx_sched
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BRK_BITS = 10,
    parameter int SH_W     = 11,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic              lead_req,
    input  logic              pre_req,
    input  logic              brk_rel,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              slot,
    input  logic              frame_end,
    output logic              load,
    output logic [SH_W-1:0]   load_pat,
    output logic [CNT_W-1:0]  load_len,
    output logic              dre,
    output logic              tc
);

    localparam int FRAME_LEN = DATA_W + 2;
    localparam int BRK_LEN   = BRK_BITS + 1;

    logic              pend_lead, pend_pre, pend_brk;
    logic [DATA_W-1:0] data_q;
    frame_kind_e       kind;

    // Pick the next frame by priority when a boundary allows it
    always_comb begin
        kind = FK_NONE;
        if (slot && ctl.en) begin
            if (pend_lead)                kind = FK_LEAD;
            else if (pend_pre)            kind = FK_PRE;
            else if (ctl.brk || pend_brk) kind = FK_BRK;
            else if (!dre)                kind = FK_DATA;
        end
    end

    // Build the shift pattern and bit count for the chosen frame
    always_comb begin
        load_pat = '1;
        load_len = '0;
        unique case (kind)
            FK_LEAD: load_len = CNT_W'(1);
            FK_PRE:  load_len = CNT_W'(FRAME_LEN);
            FK_BRK: begin
                load_pat[BRK_BITS-1:0] = '0;
                load_len = CNT_W'(BRK_LEN);
            end
            FK_DATA: begin
                load_pat[0]        = 1'b0;
                load_pat[DATA_W:1] = data_q;
                load_len = CNT_W'(FRAME_LEN);
            end
            default: load_len = '0;
        endcase
        load = (kind != FK_NONE);
    end

    // Remember queued lead-in, start delay and break requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_lead <= 1'b0;
            pend_pre  <= 1'b0;
            pend_brk  <= 1'b0;
        end else begin
            pend_lead <= lead_req || (pend_lead && kind != FK_LEAD);
            pend_pre  <= pre_req  || (pend_pre  && kind != FK_PRE);
            pend_brk  <= brk_rel  || (pend_brk  && kind != FK_BRK);
        end
    end

    // Data register and its empty flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dre    <= 1'b1;
        end else if (data_we) begin
            data_q <= data_wdata;
            dre    <= 1'b0;
        end else if (kind == FK_DATA) begin
            dre    <= 1'b1;
        end
    end

    // Transmission-complete flag
    always_ff @(posedge clk) begin
        if (!rst_n)                tc <= 1'b1;
        else if (data_we || load)  tc <= 1'b0;
        else if (frame_end)        tc <= 1'b1;
    end

endmodule

// File: rtl/sertx_shift.sv
// Frame shifter: sends a loaded pattern one bit per tick, LSB first.
// Assumes: load only arrives together with a tick on a slot; idle line is 1.
module sertx_shift #(
    parameter int SH_W  = 11,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             load,
    input  logic [SH_W-1:0]  load_pat,
    input  logic [CNT_W-1:0] load_len,
    output logic             ser_out,
    output logic             busy,
    output logic             slot,
    output logic             frame_end
);

    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;
    logic             last;

    // Boundary decode for the scheduler
    always_comb begin
        last      = busy && (cnt == CNT_W'(1));
        slot      = bit_tick && (!busy || last);
        frame_end = bit_tick && last;
        ser_out   = sh[0];
    end

    // Load, shift or retire the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (load) begin
            sh   <= load_pat;
            cnt  <= load_len;
            busy <= 1'b1;
        end else if (frame_end) begin
            sh   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (bit_tick && busy) begin
            sh   <= {1'b1, sh[SH_W-1:1]};
            cnt  <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/sertx_top.sv
// Serial frame transmitter top: control register, scheduler, shifter and
// interrupt gating. Assumes: bit_tick is a one-cycle pulse per bit time.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BRK_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTL_W-1:0]  ctrl_wdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              bit_tick,
    output logic              ser_out,
    output logic              dre_flag,
    output logic              tc_flag,
    output logic              irq_empty,
    output logic              irq_done
);

    localparam int FRAME_LEN = DATA_W + 2;
    localparam int BRK_LEN   = BRK_BITS + 1;
    localparam int SH_W      = (FRAME_LEN > BRK_LEN) ? FRAME_LEN : BRK_LEN;
    localparam int CNT_W     = $clog2(SH_W + 1);

    ctl_t             ctl;
    logic             lead_req, pre_req, brk_rel;
    logic             line_busy, slot, frame_end, load;
    logic [SH_W-1:0]  load_pat;
    logic [CNT_W-1:0] load_len;

    sertx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .line_busy  (line_busy),
        .ctl        (ctl),
        .lead_req   (lead_req),
        .pre_req    (pre_req),
        .brk_rel    (brk_rel)
    );

    sertx_sched #(
        .DATA_W   (DATA_W),
        .BRK_BITS (BRK_BITS),
        .SH_W     (SH_W),
        .CNT_W    (CNT_W)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .lead_req   (lead_req),
        .pre_req    (pre_req),
        .brk_rel    (brk_rel),
        .data_we    (data_we),
        .data_wdata (data_wdata),
        .slot       (slot),
        .frame_end  (frame_end),
        .load       (load),
        .load_pat   (load_pat),
        .load_len   (load_len),
        .dre        (dre_flag),
        .tc         (tc_flag)
    );

    sertx_shift #(
        .SH_W  (SH_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .load      (load),
        .load_pat  (load_pat),
        .load_len  (load_len),
        .ser_out   (ser_out),
        .busy      (line_busy),
        .slot      (slot),
        .frame_end (frame_end)
    );

    // Gate the two interrupt requests with their enables
    always_comb begin
        irq_empty = ctl.ie_empty && dre_flag;
        irq_done  = ctl.ie_done  && tc_flag;
    end

endmodule

// File: rtl/sertx_chk.sv
// Protocol checker for sertx_top, attached with bind.
// Assumes: busy is the shifter's frame-in-progress signal.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic data_we,
    input logic bit_tick,
    input logic ser_out,
    input logic dre_flag,
    input logic tc_flag,
    input logic irq_empty,
    input logic irq_done,
    input logic busy
);

    // R4: the empty flag rises only on the tick that moves a byte to the line
    p_dre_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dre_flag) |-> $past(bit_tick));

    // R4: the empty flag falls only after a data write
    p_dre_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dre_flag) |-> $past(data_we));

    // R5: completion is only flagged at a bit boundary
    p_tc_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_flag) |-> $past(bit_tick));

    // R3: the line changes level only on a bit tick
    p_line_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_out) |-> $past(bit_tick));

    // R6: each request implies its flag
    p_irq_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> dre_flag);
    p_irq_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> tc_flag);

    // R10: no frame in progress means an idle-high line
    p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);

endmodule

bind sertx_top sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_we   (data_we),
    .bit_tick  (bit_tick),
    .ser_out   (ser_out),
    .dre_flag  (dre_flag),
    .tc_flag   (tc_flag),
    .irq_empty (irq_empty),
    .irq_done  (irq_done),
    .busy      (line_busy)
);

// File: tb/sertx_top_test.sv
// Self-checking bench for sertx_top: directed sequences plus random data and
// random interrupt-enable patterns, line captured once per bit interval.
module sertx_top_test;

    localparam int DATA_W   = 8;
    localparam int BRK_BITS = 10;
    localparam int TICK_GAP = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_we = 1'b0;
    logic [3:0]        ctrl_wdata = '0;
    logic              data_we = 1'b0;
    logic [DATA_W-1:0] data_wdata = '0;
    logic              bit_tick = 1'b0;
    logic              ser_out, dre_flag, tc_flag, irq_empty, irq_done;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    logic cap_q[$];
    logic exp_q[$];

    sertx_top #(.DATA_W(DATA_W), .BRK_BITS(BRK_BITS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .data_we    (data_we),
        .data_wdata (data_wdata),
        .bit_tick   (bit_tick),
        .ser_out    (ser_out),
        .dre_flag   (dre_flag),
        .tc_flag    (tc_flag),
        .irq_empty  (irq_empty),
        .irq_done   (irq_done)
    );

    always #5 clk = ~clk;

    // Record one check
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bit boundary, then sample the line for that bit interval
    task automatic tick_one();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        cap_q.push_back(ser_out);
        repeat (TICK_GAP - 2) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_one();
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        @(negedge clk) begin ctrl_we = 1'b1; ctrl_wdata = v; end
        @(negedge clk) ctrl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [DATA_W-1:0] v);
        @(negedge clk) begin data_we = 1'b1; data_wdata = v; end
        @(negedge clk) data_we = 1'b0;
    endtask

    // Expected-sequence builders
    task automatic exp_data(input logic [DATA_W-1:0] b);
        exp_q.push_back(1'b0);
        for (int i = 0; i < DATA_W; i++) exp_q.push_back(b[i]);
        exp_q.push_back(1'b1);
    endtask

    task automatic exp_level(input logic v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    task automatic exp_brk();
        exp_level(1'b0, BRK_BITS);
        exp_q.push_back(1'b1);
    endtask

    // Compare captured line bits from start against the expected queue
    task automatic cmp_seg(input int start, input string req);
        int bad = -1;
        for (int i = 0; i < exp_q.size(); i++) begin
            if (bad < 0 && (start + i >= cap_q.size() || cap_q[start + i] !== exp_q[i]))
                bad = i;
        end
        if (bad < 0) chk(1'b1, req, 0, 0);
        else if (start + bad >= cap_q.size()) chk(1'b0, req, cap_q.size(), start + exp_q.size());
        else chk(1'b0, req, int'(cap_q[start + bad]), int'(exp_q[bad]));
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int st;
        logic [DATA_W-1:0] x, y;
        logic [DATA_W-1:0] rb [6];
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ser_out === 1'b1, "R1 ser_out", ser_out, 1);
        chk(dre_flag === 1'b1 && tc_flag === 1'b1, "R1 flags", {dre_flag, tc_flag}, 3);
        chk(irq_empty === 1'b0 && irq_done === 1'b0, "R1 irqs", {irq_empty, irq_done}, 0);

        // R10: disabled, a byte written stays pending and the line stays high
        wr_data(8'hA5);
        chk(dre_flag === 1'b0, "R4 clear on write", dre_flag, 0);
        st = cap_q.size();
        ticks(12);
        exp_level(1'b1, 12);
        cmp_seg(st, "R10 idle line");
        chk(dre_flag === 1'b0, "R10 byte kept", dre_flag, 0);

        // R2 / R3: enabling adds one high bit, then the pending frame
        wr_ctrl(4'b0001);
        st = cap_q.size();
        tick_one();
        tick_one();
        chk(dre_flag === 1'b1, "R4 set on load", dre_flag, 1);
        ticks(12);
        exp_level(1'b1, 1);
        exp_data(8'hA5);
        exp_level(1'b1, 3);
        cmp_seg(st, "R2 R3 delay then frame");
        chk(tc_flag === 1'b1, "R5 set after frame", tc_flag, 1);
        wr_data(8'h3C);
        chk(tc_flag === 1'b0, "R5 clear on write", tc_flag, 0);
        st = cap_q.size();
        ticks(12);
        exp_data(8'h3C);
        exp_level(1'b1, 2);
        cmp_seg(st, "R3 frame 3C");

        // R7: enable pulse low-high mid frame queues ten high bits
        x = 8'h81;
        y = 8'h5A;
        wr_data(x);
        st = cap_q.size();
        ticks(3);
        wr_ctrl(4'b0000);
        wr_ctrl(4'b0001);
        wr_data(y);
        ticks(32);
        exp_data(x);
        exp_level(1'b1, 10);
        exp_data(y);
        exp_level(1'b1, 5);
        cmp_seg(st, "R7 lead-in");
        chk(tc_flag === 1'b1, "R5 after lead-in", tc_flag, 1);

        // R8: break set then cleared mid frame gives one break afterwards
        x = 8'hF0;
        wr_data(x);
        st = cap_q.size();
        ticks(3);
        wr_ctrl(4'b0011);
        wr_ctrl(4'b0001);
        ticks(27);
        exp_data(x);
        exp_brk();
        exp_level(1'b1, 9);
        cmp_seg(st, "R8 break on release");

        // R9: held break repeats, release adds one more
        wr_ctrl(4'b0011);
        st = cap_q.size();
        ticks(22);
        wr_ctrl(4'b0001);
        ticks(20);
        exp_brk();
        exp_brk();
        exp_brk();
        exp_level(1'b1, 9);
        cmp_seg(st, "R9 held break");
        chk(tc_flag === 1'b1, "R9 complete after breaks", tc_flag, 1);

        // R3: random bytes back to back with no gap
        for (int i = 0; i < 6; i++) rb[i] = DATA_W'($urandom);
        wr_data(rb[0]);
        st = cap_q.size();
        begin
            int idx = 1;
            for (int t = 0; t < 66; t++) begin
                tick_one();
                if (dre_flag && idx < 6) begin
                    wr_data(rb[idx]);
                    idx++;
                end
            end
        end
        for (int i = 0; i < 6; i++) exp_data(rb[i]);
        exp_level(1'b1, 6);
        cmp_seg(st, "R3 random stream");

        // R6: random interrupt enables against the flags
        for (int i = 0; i < 16; i++) begin
            logic [31:0] r;
            logic edre, etc;
            r = $urandom;
            wr_ctrl({r[1], r[0], 1'b0, 1'b1});
            if (r[2]) wr_data(DATA_W'(r[15:8]));
            edre = !r[2];
            etc  = !r[2];
            chk(irq_empty === (r[0] & edre), "R6 irq_empty", irq_empty, r[0] & edre);
            chk(irq_done === (r[1] & etc), "R6 irq_done", irq_done, r[1] & etc);
            ticks(13);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule